// File: doc/BRIEF.md
# Ring Delay Line Time-Digitizer Encoder

This block is the digital back end of a time-based analog-to-digital converter. The converter has no sample-hold and no comparator. A ring of 16 delay stages circulates an edge, and the analog input sets how fast that edge travels. The block receives the 16 ring tap levels and a lap signal that toggles once per full circulation. It turns them into a count of delay stages traversed: an 18-bit lap count forms the upper bits and a 4-bit encoded edge position forms the lower bits.

On every sampling strobe the block captures this 22-bit running count. It emits the difference from the previous capture as the conversion result. A longer sampling period therefore gives more counts for the same input, and that period is the only setting that changes resolution. A start input re-arms the converter. The first result after a start is marked, because it has no valid predecessor.

Top module: `rdl_tdc_top`

## Requirements
- R1: Tap and lap inputs pass two synchronizer flops and one capture register. A ring state presented before clock edge k is the one captured by a sample strobe taken at edge k+3.
- R2: The edge position is the lowest index k in 1..15 for which tap k differs from tap k-1. When all taps are equal, the position is 0.
- R3: The 18-bit lap count advances by exactly one for each toggle of the synchronized lap input, and by no more than one per clock.
- R4: The running word places the lap count in bits 21:4 and the edge position in bits 3:0.
- R5: A sample strobe high at a clock edge makes diff_o equal to the captured word minus the previous captured word, modulo 2^22, in the following cycle.
- R6: valid_o is high for exactly one cycle per accepted sample strobe, including back-to-back strobes, and never without one.
- R7: Reset or start_i clears the lap count and the previous word to zero. The first valid_o after either one comes with first_o high, and later ones come with first_o low.
- R8: When start_i and sample_i are high in the same cycle, start wins and no valid_o follows.
- R9: diff_o holds its value in every cycle in which valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Re-arm: clears lap count and previous word |
| sample_i | input | 1 | Sampling strobe, one cycle per sampling period |
| taps_i | input | 16 | Asynchronous ring tap levels |
| lap_i | input | 1 | Asynchronous lap signal, toggles once per circulation |
| diff_o | output | 22 | Stages traversed since previous sample |
| valid_o | output | 1 | One-cycle strobe for a new difference |
| first_o | output | 1 | Marks the first difference after reset or start |

## Verification
Two events can land in the same cycle. One is a re-arm and a sampling strobe arriving together; the other is a lap toggle reaching the counter in the very cycle the running word is captured. The bench drives start_i and sample_i high on one edge and expects no strobe after it, then expects first_o on the next sample. Ring speeds near 15 stages per clock make lap toggles nearly every cycle, so captures routinely coincide with counter steps. A behavioural model built from the ring-count history predicts each difference, and any mismatch between lap bits and position bits shows up there.

// File: rtl/rdl_tdc_pkg.sv
package rdl_tdc_pkg;
  parameter int unsigned RING_STAGES = 16;
  parameter int unsigned LAP_W       = 18;
endpackage

// File: rtl/rdl_tdc_sync.sv
module rdl_tdc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rdl_tdc_enc.sv
module rdl_tdc_enc #(
  parameter int unsigned STAGES = rdl_tdc_pkg::RING_STAGES,
  localparam int unsigned POS_W = $clog2(STAGES)
) (
  input  logic [STAGES-1:0] taps_i,
  output logic [POS_W-1:0]  pos_o
);
  // descending scan so the lowest differing index wins
  always_comb begin
    pos_o = '0;
    for (int k = STAGES - 1; k >= 1; k--) begin
      if (taps_i[k] != taps_i[k-1]) pos_o = POS_W'(k);
    end
  end

  always_comb begin
    if (pos_o != '0) begin
      AST_ENC_EDGE: assert (taps_i[pos_o] != taps_i[pos_o - POS_W'(1)]); // R2
    end
  end
endmodule

// File: rtl/rdl_tdc_lap.sv
module rdl_tdc_lap #(
  parameter int unsigned CNT_W = rdl_tdc_pkg::LAP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             lap_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic lap_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lap_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lap_q <= lap_i;
      if (clr_i)              cnt_q <= '0;
      else if (lap_i != lap_q) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  AST_LAP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> (CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(1))); // R3
endmodule

// File: rtl/rdl_tdc_top.sv
module rdl_tdc_top #(
  parameter int unsigned STAGES = rdl_tdc_pkg::RING_STAGES,
  parameter int unsigned CNT_W  = rdl_tdc_pkg::LAP_W,
  localparam int unsigned POS_W  = $clog2(STAGES),
  localparam int unsigned WORD_W = CNT_W + POS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sample_i,
  input  logic [STAGES-1:0] taps_i,
  input  logic              lap_i,
  output logic [WORD_W-1:0] diff_o,
  output logic              valid_o,
  output logic              first_o
);
  logic [STAGES-1:0] taps_s;
  logic              lap_s;
  logic [POS_W-1:0]  pos_c, pos_q;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word, prev_q, diff_q;
  logic              primed_q, valid_q, first_q;

  rdl_tdc_sync #(.W(STAGES + 1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lap_i, taps_i}),
    .q_o   ({lap_s, taps_s})
  );

  rdl_tdc_enc #(.STAGES(STAGES)) u_enc (
    .taps_i(taps_s),
    .pos_o (pos_c)
  );

  rdl_tdc_lap #(.CNT_W(CNT_W)) u_lap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_i),
    .lap_i (lap_s),
    .cnt_o (cnt)
  );

  // position registered to line up with the counter stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_c;
  end

  assign word = {cnt, pos_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      diff_q   <= '0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
      first_q  <= 1'b0;
    end else if (start_i) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
      first_q  <= 1'b0;
    end else if (sample_i) begin
      diff_q   <= word - prev_q;
      prev_q   <= word;
      primed_q <= 1'b1;
      valid_q  <= 1'b1;
      first_q  <= !primed_q;
    end else begin
      valid_q  <= 1'b0;
      first_q  <= 1'b0;
    end
  end

  assign diff_o  = diff_q;
  assign valid_o = valid_q;
  assign first_o = first_q;

  AST_VALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(sample_i) && !$past(start_i))); // R6
  AST_START_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o); // R8
  AST_FIRST_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> valid_o); // R7
  AST_DIFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(diff_o)); // R9
endmodule

// File: tb/tb_rdl_tdc_top.sv
module tb_rdl_tdc_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sample_i = 1'b0;
  logic [15:0] taps_i;
  logic        lap_i;
  logic [21:0] diff_o;
  logic        valid_o, first_o;

  int unsigned n_cur = 0;
  int unsigned rate = 0;
  int total = 0, bad = 0;
  bit done = 1'b0;
  string tag = "R7";

  int unsigned hist[$];
  int unsigned base = 0;
  bit          primed = 1'b0;
  logic [21:0] prev_w = '0, exp_d = '0, last_d = '0;
  bit          exp_v = 1'b0, exp_f = 1'b0;

  always #10 clk = ~clk;

  rdl_tdc_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sample_i(sample_i),
    .taps_i(taps_i), .lap_i(lap_i), .diff_o(diff_o), .valid_o(valid_o),
    .first_o(first_o)
  );

  // ideal ring: pattern flips polarity each lap, edge at n mod 16
  function automatic logic [15:0] taps_of(int unsigned n);
    logic lp = n[4];
    for (int k = 0; k < 16; k++) taps_of[k] = (k < int'(n % 16)) ? ~lp : lp;
  endfunction

  assign taps_i = taps_of(n_cur);
  assign lap_i  = n_cur[4];

  always @(negedge clk) n_cur <= n_cur + rate;

  // behavioural reference driven by ring-count history
  always @(posedge clk) begin
    int k;
    logic [21:0] w;
    hist.push_back(n_cur);
    k = hist.size() - 1;
    if (!rst_ni) begin
      base = 0; primed = 0; prev_w = '0; exp_v = 0; exp_f = 0;
    end else if (start_i) begin
      base = (k >= 2) ? (hist[k-2] >> 4) : 0;
      primed = 0; prev_w = '0; exp_v = 0; exp_f = 0;
    end else if (sample_i && k >= 3) begin
      w = 22'(hist[k-3] - (base << 4));
      exp_d = w - prev_w; prev_w = w;
      exp_f = !primed; primed = 1; exp_v = 1;
    end else begin
      exp_v = 0; exp_f = 0;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && hist.size() > 0) begin
      check((exp_v ? tag : "R6"), "valid_o", valid_o, exp_v);
      check("R7", "first_o", first_o, exp_f);
      if (exp_v) begin
        check(tag, "diff_o", diff_o, exp_d);
        last_d = exp_d;
      end else begin
        check("R9", "diff_o held", diff_o, last_d);
      end
    end
  end

  task automatic samples(int cnt, int period);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); sample_i = 1'b1;
      @(negedge clk); sample_i = 1'b0;
      repeat (period - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R7", "reset valid_o", valid_o, 0);
    check("R7", "reset diff_o", diff_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    tag = "R7"; rate = 3;
    repeat (6) @(negedge clk);
    samples(3, 8);
    tag = "R5"; samples(4, 9);
    tag = "R1"; rate = 1; samples(4, 7);
    tag = "R2"; rate = 5; samples(6, 13);
    tag = "R3"; rate = 15; samples(5, 11);
    tag = "R4"; rate = 7; samples(3, 40); samples(3, 5);
    tag = "R6"; rate = 9; samples(1, 1);
    @(negedge clk); sample_i = 1'b1;
    repeat (6) @(negedge clk);
    sample_i = 1'b0;
    tag = "R5"; rate = 0; samples(3, 6);
    tag = "R7"; rate = 4;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    samples(3, 10);
    tag = "R8"; rate = 11;
    @(negedge clk); start_i = 1'b1; sample_i = 1'b1;
    @(negedge clk); start_i = 1'b0; sample_i = 1'b0;
    @(negedge clk);
    check("R8", "no strobe after start+sample", valid_o, 0);
    samples(4, 12);
    tag = "R3"; rate = 15; samples(20, 3);
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule